// File: doc/BRIEF.md
# MAC Control and Status Register Bank

This block is the 32-bit register bank that sits in front of an Ethernet MAC's transmit and receive engines. A host reads and writes it over a simple word bus. It holds the operating mode, the interrupt status and mask, three inter-frame gap settings, the frame length limits, the collision settings, the transmit descriptor count, a set of management-interface words, two hash filter words and the 48-bit station address. The station address is split across two bus words.

A descriptor memory occupies a window at the top half of the address space. The engines see a set of decoded outputs: run levels, one-cycle start pulses, a one-cycle engine reset, the receive descriptor start index, the minimum and maximum frame lengths, and the station address. Engine-side events set interrupt status bits through a strobe input. Software clears those bits by writing ones.

Register offsets (byte addresses, word aligned): 0x00 mode, 0x04 transmit descriptor count, 0x08 interrupt status, 0x0C interrupt mask, 0x10 frame length limits, 0x14 collision settings, 0x18 back-to-back gap, 0x1C gap part A, 0x20 gap part B, 0x24 station low word, 0x28 station high word, 0x2C hash low, 0x30 hash high, 0x34 control mode, and 0x38 through 0x4C six management words. In the mode register, bit 0 enables receive, bit 1 enables transmit and bit 11 requests a soft reset.

Top module: `macRegFile`

## Requirements
- R1: After reset the registers read: mode 0x0000A000, back-to-back gap 0x12, gap A 0x0C, gap B 0x12, frame limits 0x003C0600, collision 0x000F003F, first management word (0x38) 0x64, transmit descriptor count 0x40. Every other register reads 0. The receive descriptor index output is 0x080.
- R2: In the frame length register, bits 31:16 are the minimum frame length and bits 15:0 are the maximum. These drive minFrameLen and maxFrameLen in the cycle after the write.
- R3: Each interrupt status bit is set by a 1 on the matching evtSet bit. A write to offset 0x08 clears each bit written as 1 and leaves the others alone. If a set and a clear hit the same bit in the same cycle, the set wins. Bits at and above INT_BITS read 0.
- R4: A write to the transmit descriptor count stores only bits 7:0 of the data. In the next cycle rxDescIdx becomes that stored value shifted left by one.
- R5: The station low word holds address bytes 3,2,1,0 in bits 31:24 down to 7:0. The high word holds byte 5 in bits 15:8 and byte 4 in bits 7:0, and its bits 31:16 read 0. stationAddr carries byte N in bits 8N+7:8N.
- R6: A mode write with bit 11 set restores every register and rxDescIdx to the R1 values. It pulses engineRst for exactly one cycle, suppresses both start pulses, and leaves the descriptor memory contents unchanged.
- R7: rxRun and txRun follow mode bits 0 and 1. A mode write that takes bit 0 (or bit 1) from 0 to 1 gives a one-cycle rxStart (or txStart) pulse. Rewriting an already-set bit gives no pulse. Clearing the bit drops the run level.
- R8: Byte addresses 0x400 to 0x7FF address the descriptor memory. The word index is (address - 0x400) divided by 4, with remainders ignored.
- R9: Register offsets are decoded only when the address is word aligned and below 0x50. An access that hits neither the registers nor the memory window reads 0, and a write to such an address changes nothing.
- R10: busRdata presents the addressed word in the cycle after busRead is high and holds its value while busRead is low.
- R11: The mask, gap, collision, control, hash and management registers store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for busAddr/busWdata |
| busRead | input | 1 | Read strobe; data appears next cycle |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| evtSet | input | INT_BITS | Engine event strobes that set interrupt status bits |
| rxRun | output | 1 | Receive engine enabled |
| txRun | output | 1 | Transmit engine enabled |
| rxStart | output | 1 | One-cycle receive start pulse |
| txStart | output | 1 | One-cycle transmit start pulse |
| engineRst | output | 1 | One-cycle engine state reset from a soft reset |
| rxDescIdx | output | 9 | Receive descriptor start index |
| minFrameLen | output | 16 | Minimum frame length |
| maxFrameLen | output | 16 | Maximum frame length |
| stationAddr | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
The hardest case to reach from the ports is a clearing write to the interrupt status that lands in the same cycle as an engine event on the same bit. The stimulus drives evtSet together with the clearing write on one cycle and then reads the register back.

A second hard case is a soft reset issued while both engines run and the descriptor memory holds data. The bench checks that all registers come back to their defaults, that no start pulse appears, and that the memory words survive.

Unaligned and out-of-window accesses are mixed between real writes. A full register sweep afterwards shows that none of them touched any state.

// File: rtl/macRegPkg.sv
package macRegPkg;

  localparam int MODE_RXEN_BIT = 0;
  localparam int MODE_TXEN_BIT = 1;
  localparam int MODE_RST_BIT  = 11;
  localparam int TXCNT_W       = 8;
  localparam int NUM_REGS      = 20;

  typedef enum logic [4:0] {
    RI_MODE, RI_TXCNT, RI_INTSRC, RI_MASK, RI_PKTLEN, RI_COLL,
    RI_GAPB2B, RI_GAPA, RI_GAPB, RI_STALO, RI_STAHI, RI_HASHLO,
    RI_HASHHI, RI_CTRL, RI_MGMTMODE, RI_MGMTCMD, RI_MGMTADDR,
    RI_MGMTTX, RI_MGMTRX, RI_MGMTSTAT
  } regIdxE;

  typedef struct packed {
    logic [31:0] mode, intMask, pktLen, collCfg, gapB2b, gapA, gapB;
    logic [31:0] ctrlMode, mgmtMode, mgmtCmd, mgmtAddr, mgmtTx, mgmtRx, mgmtStat;
    logic [31:0] hashLo, hashHi;
    logic [47:0] station;
    logic [TXCNT_W-1:0] txDescCnt;
  } macRegsT;

  typedef struct packed {
    logic   regHit;
    logic   regWr;
    regIdxE regIdx;
    logic   ramHit;
    logic   ramWr;
    logic   softRst;
    logic   rd;
  } ctrlStrobeT;

  localparam macRegsT REGS_DEFAULT = '{
    mode:      32'h0000_A000,
    gapB2b:    32'h0000_0012,
    gapA:      32'h0000_000C,
    gapB:      32'h0000_0012,
    pktLen:    32'h003C_0600,
    collCfg:   32'h000F_003F,
    mgmtMode:  32'h0000_0064,
    txDescCnt: 8'h40,
    default:   '0
  };

  localparam logic [TXCNT_W:0] RXIDX_DEFAULT = {8'h40, 1'b0};

endpackage

// File: rtl/macRegCtrl.sv
module macRegCtrl
  import macRegPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DESC_BASE  = 1024,
  parameter int DESC_WORDS = 256,
  parameter int IDX_W      = 8
) (
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rstBitIn,
  output ctrlStrobeT        strb,
  output logic [IDX_W-1:0]  ramIdx
);
  localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(DESC_BASE);
  localparam logic [ADDR_W:0] WIN_HI  = (ADDR_W+1)'(DESC_BASE + 4*DESC_WORDS);
  localparam logic [ADDR_W:0] REG_END = (ADDR_W+1)'(4*NUM_REGS);

  logic [ADDR_W:0] addrExt;
  logic [ADDR_W:0] winOff;

  assign addrExt = {1'b0, busAddr};
  assign winOff  = addrExt - WIN_LO;
  assign ramIdx  = IDX_W'(winOff >> 2);

  always_comb begin
    strb         = '0;
    strb.regIdx  = regIdxE'(busAddr[6:2]);
    strb.regHit  = (busAddr[1:0] == 2'b00) && (addrExt < REG_END);
    strb.ramHit  = (addrExt >= WIN_LO) && (addrExt < WIN_HI);
    strb.regWr   = busWrite && strb.regHit;
    strb.ramWr   = busWrite && strb.ramHit;
    strb.softRst = strb.regWr && (strb.regIdx == RI_MODE) && rstBitIn;
    strb.rd      = busRead;
  end
endmodule

// File: rtl/macDescRam.sv
module macDescRam #(
  parameter int WORDS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdWord
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wrEn) mem[idx] <= wdata;
  end

  assign rdWord = mem[idx];
endmodule

// File: rtl/macRegDatapath.sv
module macRegDatapath
  import macRegPkg::*;
#(
  parameter int INT_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strb,
  input  logic [31:0]         busWdata,
  input  logic [INT_BITS-1:0] evtSet,
  input  logic [31:0]         ramRdWord,
  output logic [31:0]         busRdata,
  output logic                rxRun,
  output logic                txRun,
  output logic                rxStart,
  output logic                txStart,
  output logic                engineRst,
  output logic [TXCNT_W:0]    rxDescIdx,
  output logic [15:0]         minFrameLen,
  output logic [15:0]         maxFrameLen,
  output logic [47:0]         stationAddr
);
  macRegsT             regs;
  logic [INT_BITS-1:0] intSrc;
  logic [INT_BITS-1:0] clrMask;
  logic [31:0]         regVal;
  logic [31:0]         rdNext;
  logic                modeWr;

  assign modeWr  = strb.regWr && (strb.regIdx == RI_MODE);
  assign clrMask = (strb.regWr && strb.regIdx == RI_INTSRC) ? busWdata[INT_BITS-1:0] : '0;

  always_comb begin
    case (strb.regIdx)
      RI_MODE:     regVal = regs.mode;
      RI_TXCNT:    regVal = {{(32-TXCNT_W){1'b0}}, regs.txDescCnt};
      RI_INTSRC:   regVal = {{(32-INT_BITS){1'b0}}, intSrc};
      RI_MASK:     regVal = regs.intMask;
      RI_PKTLEN:   regVal = regs.pktLen;
      RI_COLL:     regVal = regs.collCfg;
      RI_GAPB2B:   regVal = regs.gapB2b;
      RI_GAPA:     regVal = regs.gapA;
      RI_GAPB:     regVal = regs.gapB;
      RI_STALO:    regVal = regs.station[31:0];
      RI_STAHI:    regVal = {16'h0, regs.station[47:32]};
      RI_HASHLO:   regVal = regs.hashLo;
      RI_HASHHI:   regVal = regs.hashHi;
      RI_CTRL:     regVal = regs.ctrlMode;
      RI_MGMTMODE: regVal = regs.mgmtMode;
      RI_MGMTCMD:  regVal = regs.mgmtCmd;
      RI_MGMTADDR: regVal = regs.mgmtAddr;
      RI_MGMTTX:   regVal = regs.mgmtTx;
      RI_MGMTRX:   regVal = regs.mgmtRx;
      RI_MGMTSTAT: regVal = regs.mgmtStat;
      default:     regVal = '0;
    endcase
    if (strb.ramHit)      rdNext = ramRdWord;
    else if (strb.regHit) rdNext = regVal;
    else                  rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs      <= REGS_DEFAULT;
      intSrc    <= '0;
      rxDescIdx <= RXIDX_DEFAULT;
      rxStart   <= 1'b0;
      txStart   <= 1'b0;
      engineRst <= 1'b0;
      busRdata  <= '0;
    end else begin
      if (strb.rd) busRdata <= rdNext;
      if (strb.softRst) begin
        regs      <= REGS_DEFAULT;
        intSrc    <= '0;
        rxDescIdx <= RXIDX_DEFAULT;
        rxStart   <= 1'b0;
        txStart   <= 1'b0;
        engineRst <= 1'b1;
      end else begin
        engineRst <= 1'b0;
        rxStart   <= modeWr && busWdata[MODE_RXEN_BIT] && !regs.mode[MODE_RXEN_BIT];
        txStart   <= modeWr && busWdata[MODE_TXEN_BIT] && !regs.mode[MODE_TXEN_BIT];
        intSrc    <= (intSrc & ~clrMask) | evtSet;
        if (strb.regWr) begin
          case (strb.regIdx)
            RI_MODE:     regs.mode <= busWdata;
            RI_TXCNT: begin
              regs.txDescCnt <= busWdata[TXCNT_W-1:0];
              rxDescIdx      <= {busWdata[TXCNT_W-1:0], 1'b0};
            end
            RI_MASK:     regs.intMask  <= busWdata;
            RI_PKTLEN:   regs.pktLen   <= busWdata;
            RI_COLL:     regs.collCfg  <= busWdata;
            RI_GAPB2B:   regs.gapB2b   <= busWdata;
            RI_GAPA:     regs.gapA     <= busWdata;
            RI_GAPB:     regs.gapB     <= busWdata;
            RI_STALO:    regs.station[31:0]  <= busWdata;
            RI_STAHI:    regs.station[47:32] <= busWdata[15:0];
            RI_HASHLO:   regs.hashLo   <= busWdata;
            RI_HASHHI:   regs.hashHi   <= busWdata;
            RI_CTRL:     regs.ctrlMode <= busWdata;
            RI_MGMTMODE: regs.mgmtMode <= busWdata;
            RI_MGMTCMD:  regs.mgmtCmd  <= busWdata;
            RI_MGMTADDR: regs.mgmtAddr <= busWdata;
            RI_MGMTTX:   regs.mgmtTx   <= busWdata;
            RI_MGMTRX:   regs.mgmtRx   <= busWdata;
            RI_MGMTSTAT: regs.mgmtStat <= busWdata;
            default: ;
          endcase
        end
      end
    end
  end

  assign rxRun       = regs.mode[MODE_RXEN_BIT];
  assign txRun       = regs.mode[MODE_TXEN_BIT];
  assign minFrameLen = regs.pktLen[31:16];
  assign maxFrameLen = regs.pktLen[15:0];
  assign stationAddr = regs.station;
endmodule

// File: rtl/macRegFile.sv
module macRegFile
  import macRegPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DESC_BASE  = 1024,
  parameter int DESC_WORDS = 256,
  parameter int INT_BITS   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [INT_BITS-1:0] evtSet,
  output logic                rxRun,
  output logic                txRun,
  output logic                rxStart,
  output logic                txStart,
  output logic                engineRst,
  output logic [8:0]          rxDescIdx,
  output logic [15:0]         minFrameLen,
  output logic [15:0]         maxFrameLen,
  output logic [47:0]         stationAddr
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  ctrlStrobeT       strb;
  logic [IDX_W-1:0] ramIdx;
  logic [31:0]      ramRdWord;

  macRegCtrl #(
    .ADDR_W(ADDR_W), .DESC_BASE(DESC_BASE), .DESC_WORDS(DESC_WORDS), .IDX_W(IDX_W)
  ) uCtrl (
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .rstBitIn(busWdata[MODE_RST_BIT]), .strb(strb), .ramIdx(ramIdx)
  );

  macDescRam #(.WORDS(DESC_WORDS), .IDX_W(IDX_W)) uRam (
    .clk(clk), .wrEn(strb.ramWr), .idx(ramIdx), .wdata(busWdata), .rdWord(ramRdWord)
  );

  macRegDatapath #(.INT_BITS(INT_BITS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .evtSet(evtSet),
    .ramRdWord(ramRdWord), .busRdata(busRdata), .rxRun(rxRun), .txRun(txRun),
    .rxStart(rxStart), .txStart(txStart), .engineRst(engineRst),
    .rxDescIdx(rxDescIdx), .minFrameLen(minFrameLen), .maxFrameLen(maxFrameLen),
    .stationAddr(stationAddr)
  );
endmodule

// File: rtl/macRegFileChk.sv
module macRegFileChk
  import macRegPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busWrite,
  input logic       rxRun,
  input logic       txRun,
  input logic       rxStart,
  input logic       txStart,
  input logic       engineRst,
  input logic [8:0] rxDescIdx
);
  p_rx_start_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxStart |-> (rxRun && !$past(rxRun)));

  p_tx_start_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txRun && !$past(txRun)));

  p_run_needs_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxRun) |-> $past(busWrite));

  p_soft_reset_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    engineRst |-> (!rxRun && !txRun && !rxStart && !txStart && rxDescIdx == RXIDX_DEFAULT));

  p_idx_needs_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxDescIdx) |-> $past(busWrite));

  p_idx_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxDescIdx[0]);
endmodule

bind macRegFile macRegFileChk uChk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .rxRun(rxRun), .txRun(txRun),
  .rxStart(rxStart), .txStart(txStart), .engineRst(engineRst), .rxDescIdx(rxDescIdx)
);

// File: tb/tb_macRegFile.sv
module tb_macRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [10:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [6:0]  evtSet = '0;
  logic        rxRun, txRun, rxStart, txStart, engineRst;
  logic [8:0]  rxDescIdx;
  logic [15:0] minFrameLen, maxFrameLen;
  logic [47:0] stationAddr;

  int vectors = 0;
  int miscompares = 0;

  macRegFile dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtSet(evtSet), .rxRun(rxRun),
    .txRun(txRun), .rxStart(rxStart), .txStart(txStart), .engineRst(engineRst),
    .rxDescIdx(rxDescIdx), .minFrameLen(minFrameLen), .maxFrameLen(maxFrameLen),
    .stationAddr(stationAddr)
  );

  always #2 clk = ~clk;

  // Behavioural reference: register image indexed by offset/4, memory as a sparse map
  logic [31:0] mr [20];
  logic [31:0] ram [int];
  logic [31:0] mRdata = '0;
  logic [8:0]  mIdx;
  logic        mRxStart = 0, mTxStart = 0, mEng = 0;

  function automatic void loadDefaults();
    for (int i = 0; i < 20; i++) mr[i] = '0;
    mr[0] = 32'h0000A000; mr[1] = 32'h40; mr[4] = 32'h003C0600; mr[5] = 32'h000F003F;
    mr[6] = 32'h12; mr[7] = 32'h0C; mr[8] = 32'h12; mr[14] = 32'h64;
    mIdx = 9'h080;
  endfunction

  function automatic logic [31:0] mread(int a);
    if (a >= 1024 && a < 2048) return ram.exists((a - 1024) / 4) ? ram[(a - 1024) / 4] : 32'hx;
    if (a % 4 == 0 && a < 80) return mr[a / 4];
    return '0;
  endfunction

  task automatic cyc(bit wr, bit rd, int a, logic [31:0] d, logic [6:0] evt, string tag);
    logic [31:0] newRd;
    logic [31:0] clr;
    logic [47:0] expSta;
    busWrite = wr; busRead = rd; busAddr = 11'(a); busWdata = d; evtSet = evt;
    @(posedge clk);
    newRd = rd ? mread(a) : mRdata;
    mRxStart = 0; mTxStart = 0; mEng = 0; clr = '0;
    if (wr && a == 0 && d[11]) begin
      loadDefaults();
      mEng = 1;
    end else begin
      if (wr && a % 4 == 0 && a < 80) begin
        case (a / 4)
          0: begin
            mRxStart = d[0] && !mr[0][0];
            mTxStart = d[1] && !mr[0][1];
            mr[0] = d;
          end
          1: begin mr[1] = d & 32'hFF; mIdx = {d[7:0], 1'b0}; end
          2: clr = d & 32'h7F;
          10: mr[10] = d & 32'hFFFF;
          default: mr[a / 4] = d;
        endcase
      end else if (wr && a >= 1024 && a < 2048) begin
        ram[(a - 1024) / 4] = d;
      end
      mr[2] = (mr[2] & ~clr) | {25'b0, evt};
    end
    mRdata = newRd;
    @(negedge clk);
    vectors++;
    expSta = {mr[10][15:0], mr[9]};
    if (busRdata !== mRdata || rxRun !== mr[0][0] || txRun !== mr[0][1] ||
        rxStart !== mRxStart || txStart !== mTxStart || engineRst !== mEng ||
        rxDescIdx !== mIdx || minFrameLen !== mr[4][31:16] ||
        maxFrameLen !== mr[4][15:0] || stationAddr !== expSta) begin
      miscompares++;
      $display("FAIL %s @%0t: rdata %h/%h run %b%b/%b%b start %b%b/%b%b eng %b/%b idx %h/%h len %h:%h/%h:%h sta %h/%h",
               tag, $time, busRdata, mRdata, rxRun, txRun, mr[0][0], mr[0][1],
               rxStart, txStart, mRxStart, mTxStart, engineRst, mEng, rxDescIdx, mIdx,
               minFrameLen, maxFrameLen, mr[4][31:16], mr[4][15:0], stationAddr, expSta);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    cyc(1, 0, a, d, '0, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(0, 1, a, '0, '0, tag);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 20; i++) rd(i * 4, tag);
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    loadDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(0, 0, 0, '0, '0, "R1 idle after reset");
    sweep("R1 reset values");

    wr(16, 32'h0040_1234, "R2 frame limits");
    rd(16, "R2 readback");
    wr(16, 32'hFFFF_0001, "R2 extreme limits");

    wr(12, 32'hDEAD_BEEF, "R11 mask");
    wr(20, 32'h8000_0001, "R11 collision");
    wr(44, 32'h1234_5678, "R11 hash low");
    wr(48, 32'hFFFF_FFFF, "R11 hash high");
    wr(56, 32'hA5A5_5A5A, "R11 mgmt mode");
    wr(76, 32'h0F0F_F0F0, "R11 mgmt status");
    sweep("R11 readback");

    wr(36, 32'h4433_2211, "R5 station low");
    wr(40, 32'hABCD_6655, "R5 station high");
    rd(40, "R5 high upper zero");
    rd(36, "R5 low readback");

    cyc(0, 0, 0, '0, 7'h55, "R3 event set");
    rd(8, "R3 status after set");
    wr(8, 32'hFFFF_FF05, "R3 clear bits 0 and 2");
    rd(8, "R3 status after clear");
    cyc(1, 0, 8, 32'h0000_0010, 7'h10, "R3 set wins over clear");
    rd(8, "R3 status after collision");
    cyc(1, 0, 8, 32'h0000_0040, 7'h01, "R3 clear one while setting other");
    rd(8, "R3 status");
    wr(8, 32'h0000_0000, "R3 zero write no effect");
    rd(8, "R3 status unchanged");

    wr(4, 32'h0000_01FF, "R4 count truncated");
    rd(4, "R4 count readback");
    wr(4, 32'h0000_0007, "R4 small count");
    rd(4, "R4 count readback");

    wr(0, 32'h0000_A001, "R7 rx enable");
    wr(0, 32'h0000_A003, "R7 tx enable only");
    wr(0, 32'h0000_A003, "R7 rewrite no pulse");
    wr(0, 32'h0000_A002, "R7 rx disable");
    wr(0, 32'h0000_A003, "R7 rx restart");
    rd(0, "R7 mode readback");

    wr(1024, 32'h1111_0000, "R8 first word");
    wr(2044, 32'h2222_FFFF, "R8 last word");
    wr(1280, 32'h3333_ABCD, "R8 middle word");
    rd(1024, "R8 read first");
    rd(2044, "R8 read last");
    rd(1281, "R8 unaligned within window");
    wr(1283, 32'h4444_0000, "R8 unaligned write");
    rd(1280, "R8 unaligned write target");

    wr(80, 32'hFFFF_FFFF, "R9 write past registers");
    wr(1020, 32'hFFFF_FFFF, "R9 write below window");
    wr(10, 32'hFFFF_FFFF, "R9 unaligned register write");
    wr(2, 32'hFFFF_FFFF, "R9 unaligned mode write");
    rd(80, "R9 unmapped read zero");
    rd(1020, "R9 unmapped read zero");
    rd(6, "R9 unaligned read zero");
    sweep("R9 nothing changed");

    rd(16, "R10 read");
    cyc(0, 0, 0, '0, '0, "R10 hold");
    cyc(0, 0, 36, '0, '0, "R10 hold after address change");

    cyc(0, 0, 0, '0, 7'h7F, "R6 status before reset");
    cyc(1, 0, 0, 32'h0000_0803, 7'h7F, "R6 soft reset");
    cyc(0, 0, 0, '0, '0, "R6 pulse ends");
    sweep("R6 defaults restored");
    rd(1024, "R6 memory kept");
    rd(2044, "R6 memory kept");
    wr(0, 32'h0000_A001, "R7 start after soft reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule